// File: doc/BRIEF.md
# DTMF Digit Validity Qualifier

This block sits behind a tone-pair detector and turns its raw, per-sample decision into a steady digit report. On every sample it receives a flag saying whether a valid tone pair is present and a 4-bit code naming which pair. A digit is reported only after the same code has been present long enough. The report survives short dropouts inside the tone, and it is withdrawn only after a real interdigit gap. Its two outputs, a valid flag and a 4-bit code, can be packed straight into a status byte.

Time is measured in samples. With the block clocked from a fast system clock, a one-cycle sample strobe marks each 8 kHz sample. A build-time option instead treats every clock as a sample. At 8 kHz, the default limits are 320 samples (40 ms) to accept a tone or a gap, and 160 samples (20 ms) below which either one is always refused. A duration that falls between the two limits is decided by the accept limit, so only a run that reaches the accept limit counts.

Top module: `dtmf_digit_qualifier`

## Requirements
- R1: While reset is asserted and right after it is released, `digit_valid` is 0 and `digit_code` is 0.
- R2: With no digit reported, `digit_valid` rises on the clock edge that takes in the TONE_ACCEPT-th (default 320) consecutive present sample carrying one code. A run of that code that stops after fewer samples, including any run of TONE_REJECT (160) samples or fewer, never sets `digit_valid`.
- R3: If the code changes during a present run before acceptance, the count restarts at the first sample of the new code. The new code then needs a full TONE_ACCEPT samples of its own.
- R4: A single absent sample before acceptance restarts the tone count.
- R5: While a digit is reported, any run of fewer than GAP_ACCEPT (default 320) consecutive absent samples leaves `digit_valid` at 1 and `digit_code` unchanged. This includes any gap of GAP_REJECT (160) samples or fewer.
- R6: While a digit is reported, `digit_valid` falls on the edge that takes in the GAP_ACCEPT-th consecutive absent sample.
- R7: While `digit_valid` is 0, `digit_code` keeps the last reported code and does not change. It changes only when the next digit is accepted.
- R8: While a digit is reported, a present tone with a different code does not replace `digit_code`. The new digit can only be reported after a qualified gap has dropped `digit_valid`.
- R9: The reported code is the accepted input code, bit for bit: digits 0 to 9 are 0000 to 1001, A to D are 1010 to 1101, * is 1110 and # is 1111. All 16 values are accepted.
- R10: In strobe mode (USE_STROBE=1), clock edges with `smp_en` low change neither output, whatever the tone inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_en | input | 1 | One-cycle strobe per sample (ignored when USE_STROBE=0) |
| tone_present | input | 1 | Raw detector decision: a tone pair is present in this sample |
| tone_code | input | CODE_W | Raw detector code of the present pair |
| digit_valid | output | 1 | Qualified digit is being reported |
| digit_code | output | CODE_W | Reported digit code, held after the digit ends |

## Verification
The directed patterns bracket each limit by one sample: a tone one sample short of acceptance against one that just reaches it, and a gap one sample short of release against one that just reaches it. These tell an off-by-one in either counter from a correct design. Runs whose code switches mid-way, and tones broken by one absent sample, separate a counter that restarts from one that only pauses. A foreign code held during a reported digit shows whether the report can be overwritten without a gap. Randomly timed segments of present and absent samples, with lengths clustered around both limits, are compared sample by sample against a model in the bench. Garbage on the tone inputs between strobes shows whether samples leak in outside the strobe.

// File: rtl/dtq_pkg.sv
package dtq_pkg;

   localparam int DIGIT_W = 4;

   typedef enum logic {
      QS_IDLE = 1'b0,
      QS_HELD = 1'b1
   } qual_state_e;

   function automatic int cnt_width(input int limit);
      return $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/dtq_sample_gate.sv
module dtq_sample_gate #(
   parameter bit USE_STROBE = 1'b1
) (
   input  logic smp_en,
   output logic step_o
);

   generate
      if (USE_STROBE) begin : g_strobe
         assign step_o = smp_en;
      end else begin : g_every_clock
         logic unused_strobe;
         assign unused_strobe = smp_en;
         assign step_o        = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/dtq_run_counter.sv
module dtq_run_counter #(
   parameter int LIMIT = 320,
   localparam int W    = dtq_pkg::cnt_width(LIMIT)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   input  logic         hit_i,
   input  logic         cont_i,
   output logic         live_o,
   output logic         reach_o
);

   localparam logic [W-1:0] LIM = W'(LIMIT);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;

   always_comb begin
      if (!hit_i) begin
         cnt_d = '0;
      end else if (!cont_i) begin
         cnt_d = ONE;
      end else if (cnt_q == LIM) begin
         cnt_d = LIM;
      end else begin
         cnt_d = cnt_q + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= cnt_d;
      end
   end

   assign live_o  = (cnt_q != '0);
   assign reach_o = step_i && (cnt_d == LIM) && (cnt_q != LIM);

endmodule

// File: rtl/dtq_tracker.sv
module dtq_tracker #(
   parameter int CODE_W = dtq_pkg::DIGIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              present_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              tone_live_i,
   input  logic              tone_reach_i,
   input  logic              gap_reach_i,
   output logic              same_code_o,
   output logic              valid_o,
   output logic [CODE_W-1:0] code_o
);

   import dtq_pkg::*;

   qual_state_e       st_q;
   qual_state_e       st_d;
   logic [CODE_W-1:0] cand_q;
   logic [CODE_W-1:0] code_q;

   assign same_code_o = tone_live_i && (code_i == cand_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q <= '0;
      end else if (step_i && present_i) begin
         cand_q <= code_i;
      end
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         QS_IDLE: if (tone_reach_i) st_d = QS_HELD;
         QS_HELD: if (gap_reach_i)  st_d = QS_IDLE;
         default: st_d = QS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= QS_IDLE;
         code_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == QS_IDLE && tone_reach_i) begin
            code_q <= code_i;
         end
      end
   end

   assign valid_o = (st_q == QS_HELD);
   assign code_o  = code_q;

endmodule

// File: rtl/dtmf_digit_qualifier.sv
module dtmf_digit_qualifier #(
   parameter int CODE_W      = dtq_pkg::DIGIT_W,
   parameter int TONE_ACCEPT = 320,
   parameter int TONE_REJECT = 160,
   parameter int GAP_ACCEPT  = 320,
   parameter int GAP_REJECT  = 160,
   parameter bit USE_STROBE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_en,
   input  logic              tone_present,
   input  logic [CODE_W-1:0] tone_code,
   output logic              digit_valid,
   output logic [CODE_W-1:0] digit_code
);

   generate
      if (CODE_W < 1) begin : g_bad_width
         $error("CODE_W must be at least 1");
      end
      if (TONE_ACCEPT < 2 || GAP_ACCEPT < 2) begin : g_bad_accept
         $error("accept limits must be at least 2 samples");
      end
      if (TONE_REJECT >= TONE_ACCEPT) begin : g_bad_tone_win
         $error("TONE_REJECT must be below TONE_ACCEPT");
      end
      if (GAP_REJECT >= GAP_ACCEPT) begin : g_bad_gap_win
         $error("GAP_REJECT must be below GAP_ACCEPT");
      end
   endgenerate

   logic step;
   logic tone_live;
   logic tone_reach;
   logic gap_live;
   logic gap_reach;
   logic same_code;
   logic unused_gap_live;

   assign unused_gap_live = gap_live;

   dtq_sample_gate #(
      .USE_STROBE (USE_STROBE)
   ) u_gate (
      .smp_en (smp_en),
      .step_o (step)
   );

   dtq_run_counter #(
      .LIMIT (TONE_ACCEPT)
   ) u_tone_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_i  (step),
      .hit_i   (tone_present),
      .cont_i  (same_code),
      .live_o  (tone_live),
      .reach_o (tone_reach)
   );

   dtq_run_counter #(
      .LIMIT (GAP_ACCEPT)
   ) u_gap_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_i  (step),
      .hit_i   (!tone_present),
      .cont_i  (1'b1),
      .live_o  (gap_live),
      .reach_o (gap_reach)
   );

   dtq_tracker #(
      .CODE_W (CODE_W)
   ) u_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .step_i       (step),
      .present_i    (tone_present),
      .code_i       (tone_code),
      .tone_live_i  (tone_live),
      .tone_reach_i (tone_reach),
      .gap_reach_i  (gap_reach),
      .same_code_o  (same_code),
      .valid_o      (digit_valid),
      .code_o       (digit_code)
   );

endmodule

// File: rtl/dtmf_digit_qualifier_chk.sv
module dtmf_digit_qualifier_chk #(
   parameter int CODE_W      = dtq_pkg::DIGIT_W,
   parameter int TONE_ACCEPT = 320,
   parameter int TONE_REJECT = 160,
   parameter int GAP_ACCEPT  = 320,
   parameter int GAP_REJECT  = 160,
   parameter bit USE_STROBE  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_en,
   input logic              tone_present,
   input logic [CODE_W-1:0] tone_code,
   input logic              digit_valid,
   input logic [CODE_W-1:0] digit_code
);

   logic              chk_step;
   int unsigned       run_q;
   int unsigned       quiet_q;
   logic [CODE_W-1:0] last_q;
   int                unused_rej;

   assign unused_rej = TONE_REJECT + GAP_REJECT;
   assign chk_step   = USE_STROBE ? smp_en : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 0;
         quiet_q <= 0;
         last_q  <= '0;
      end else if (chk_step) begin
         if (tone_present) begin
            quiet_q <= 0;
            last_q  <= tone_code;
            if (run_q != 0 && tone_code == last_q) begin
               if (run_q < TONE_ACCEPT) run_q <= run_q + 1;
            end else begin
               run_q <= 1;
            end
         end else begin
            run_q <= 0;
            if (quiet_q < GAP_ACCEPT) quiet_q <= quiet_q + 1;
         end
      end
   end

   AST_ACCEPT_AFTER_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(digit_valid) |-> (run_q >= TONE_ACCEPT)); // R2

   AST_ACCEPT_TAKES_RUN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(digit_valid) |-> (digit_code == last_q)); // R9

   AST_RELEASE_AFTER_FULL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(digit_valid) |-> (quiet_q >= GAP_ACCEPT)); // R6

   AST_CODE_FIXED_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (digit_valid && $past(digit_valid)) |-> $stable(digit_code)); // R8

   AST_CODE_FIXED_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !digit_valid |-> $stable(digit_code)); // R7

   generate
      if (USE_STROBE) begin : g_strobe_chk
         AST_NO_CHANGE_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(smp_en) |-> ($stable(digit_valid) && $stable(digit_code))); // R10
      end
   endgenerate

endmodule

bind dtmf_digit_qualifier dtmf_digit_qualifier_chk #(
   .CODE_W      (CODE_W),
   .TONE_ACCEPT (TONE_ACCEPT),
   .TONE_REJECT (TONE_REJECT),
   .GAP_ACCEPT  (GAP_ACCEPT),
   .GAP_REJECT  (GAP_REJECT),
   .USE_STROBE  (USE_STROBE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .smp_en       (smp_en),
   .tone_present (tone_present),
   .tone_code    (tone_code),
   .digit_valid  (digit_valid),
   .digit_code   (digit_code)
);

// File: tb/dtmf_digit_qualifier_tb.sv
module dtmf_digit_qualifier_tb;

   localparam int ACC_ON  = 320;
   localparam int REJ_ON  = 160;
   localparam int ACC_OFF = 320;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       smp_en = 1'b0;
   logic       tone_present = 1'b0;
   logic [3:0] tone_code = 4'h0;
   logic       digit_valid;
   logic [3:0] digit_code;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;

   int         m_on  = 0;
   int         m_off = 0;
   bit         m_valid = 1'b0;
   logic [3:0] m_code  = 4'h0;
   logic [3:0] m_cand  = 4'h0;

   always #4 clk = ~clk;

   dtmf_digit_qualifier u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .smp_en       (smp_en),
      .tone_present (tone_present),
      .tone_code    (tone_code),
      .digit_valid  (digit_valid),
      .digit_code   (digit_code)
   );

   task automatic check(input string tag, input bit exp_v, input logic [3:0] exp_c);
      n_cmp++;
      if (digit_valid !== exp_v || digit_code !== exp_c) begin
         n_bad++;
         $display("FAIL %s: valid=%0b code=%h, expected valid=%0b code=%h",
                  tag, digit_valid, digit_code, exp_v, exp_c);
      end
   endtask

   // Requirement-level model of one sample
   task automatic model_step(input bit p, input logic [3:0] c);
      if (p) begin
         if (m_on > 0 && c == m_cand) begin
            if (m_on < ACC_ON) m_on++;
         end else begin
            m_on = 1;
         end
         m_cand = c;
         m_off  = 0;
         if (!m_valid && m_on == ACC_ON) begin
            m_valid = 1'b1;
            m_code  = c;
         end
      end else begin
         m_on = 0;
         if (m_off < ACC_OFF) m_off++;
         if (m_valid && m_off == ACC_OFF) m_valid = 1'b0;
      end
   endtask

   task automatic sample(input bit p, input logic [3:0] c, input string tag);
      @(negedge clk);
      check("R10 hold between strobes", m_valid, m_code);
      smp_en       = 1'b1;
      tone_present = p;
      tone_code    = c;
      model_step(p, c);
      @(negedge clk);
      check(tag, m_valid, m_code);
      smp_en       = 1'b0;
      tone_present = 1'($urandom_range(0, 1));
      tone_code    = 4'($urandom_range(0, 15));
   endtask

   task automatic run(input bit p, input logic [3:0] c, input int len, input string tag);
      for (int i = 0; i < len; i++) sample(p, c, tag);
   endtask

   initial begin
      void'($urandom(32'h5EED_0D7F));
      repeat (3) @(negedge clk);
      check("R1 in reset", 1'b0, 4'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 1'b0, 4'h0);

      // R2: one short of accept, then a rejected short tone
      run(1'b1, 4'h5, ACC_ON - 1, "R2 short tone");
      run(1'b0, 4'h0, 1, "R2 short tone");
      check("R2 319 samples not accepted", 1'b0, 4'h0);
      run(1'b1, 4'h5, REJ_ON, "R2 reject window");
      run(1'b0, 4'h0, 1, "R2 reject window");
      check("R2 160 samples not accepted", 1'b0, 4'h0);

      // R3: code switch restarts the count
      run(1'b1, 4'h7, 200, "R3 first code");
      run(1'b1, 4'hA, ACC_ON - 1, "R3 restarted count");
      check("R3 not yet accepted", 1'b0, 4'h0);
      run(1'b1, 4'hA, 1, "R3 accepted");
      check("R3 accepted A", 1'b1, 4'hA);

      // R5 / R6 / R7: gap limits
      run(1'b0, 4'h0, ACC_OFF - 1, "R5 short gap");
      check("R5 still valid", 1'b1, 4'hA);
      run(1'b1, 4'hA, 10, "R5 tone resumes");
      run(1'b0, 4'h0, ACC_OFF, "R6 full gap");
      check("R6 dropped", 1'b0, 4'hA);
      check("R7 code held", 1'b0, 4'hA);

      // R4: single dropout restarts
      run(1'b1, 4'h3, 300, "R4 before dropout");
      run(1'b0, 4'h3, 1, "R4 dropout");
      run(1'b1, 4'h3, 300, "R4 after dropout");
      check("R4 not accepted", 1'b0, 4'hA);
      run(1'b1, 4'h3, 20, "R4 complete run");
      check("R4 accepted 3", 1'b1, 4'h3);

      // R8: foreign code while held
      run(1'b1, 4'h9, 400, "R8 foreign code");
      check("R8 code kept", 1'b1, 4'h3);
      run(1'b0, 4'h0, ACC_OFF, "R8 gap");
      run(1'b1, 4'h9, ACC_ON, "R8 new digit");
      check("R8 new digit reported", 1'b1, 4'h9);
      run(1'b0, 4'h0, ACC_OFF, "R6 gap");

      // R9: every code value
      for (int d = 0; d < 16; d++) begin
         run(1'b1, 4'(d), ACC_ON, "R9 code map");
         check("R9 code value", 1'b1, 4'(d));
         run(1'b0, 4'h0, ACC_OFF, "R9 gap");
      end

      // Random segments clustered around both limits
      begin
         logic [3:0] rc = 4'h1;
         for (int s = 0; s < 110; s++) begin
            int len;
            int cls;
            bit p;
            p   = 1'($urandom_range(0, 1));
            cls = $urandom_range(0, 2);
            if (cls == 0)      len = $urandom_range(1, 170);
            else if (cls == 1) len = $urandom_range(150, 330);
            else               len = $urandom_range(300, 360);
            if ($urandom_range(0, 3) == 0) rc = 4'($urandom_range(0, 15));
            run(p, rc, len, "random R3 R4 R5 R6");
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule